// File: doc/BRIEF.md
# Flash Completion Polling Checker

This block runs on the host side of a parallel flash and decides when an embedded program or erase operation has ended, and whether it ended well. After a start pulse it reads the status byte from a fixed valid address over a simple request/response handshake. It keeps reading until it can reach a verdict. It then raises a one-cycle done pulse together with a pass flag and a timeout flag.

Two polling methods are selectable at start:
- **Data polling** compares bit 7 of each status read with bit 7 of the byte that was programmed.
- **Toggle polling** watches whether bit 6 changes between consecutive reads.

In both methods bit 5 is the device error indication. A set error bit never causes a failure on its own. It triggers one extra confirming read, because the operation may have completed in the same moment the error bit appeared. A programmable read budget bounds the whole check, so a device that never settles still yields a failed, timed-out result.

The physical bus timing of the flash is handled elsewhere. This block only issues read requests and consumes returned bytes.

Top module: `flash_done_poller`

## Requirements
- R1: After reset `rdReq`, `done`, `pass` and `timeout` are all low.
- R2: A `start` pulse seen while idle samples `toggleMode`, `expData` and `readLimit`, and raises `rdReq` on the following cycle. A `start` pulse while a check is in progress has no effect on the result or on the number of reads.
- R3: At most one read is outstanding. `rdReq` stays high until a cycle with `rdValid` high, and each such cycle consumes exactly one status byte. `rdReq` is low while idle.
- R4: In data polling (`toggleMode`=0), a read whose bit 7 equals `expData[7]` ends the check with pass.
- R5: In data polling, a read whose bit 7 differs from `expData[7]` with bit 5 clear leads to another read.
- R6: In data polling, a read whose bit 7 differs with bit 5 set leads to exactly one confirming read. The result is pass if that read's bit 7 equals `expData[7]`, and fail otherwise.
- R7: In toggle polling (`toggleMode`=1), the first read only records bit 6 and never decides.
- R8: In toggle polling, a read whose bit 6 equals bit 6 of the previous read ends with pass. If bit 6 changed and bit 5 is clear, another read follows.
- R9: In toggle polling, a read with a changed bit 6 and bit 5 set leads to one confirming read. The result is pass if that read's bit 6 equals bit 6 of the error read, and fail otherwise.
- R10: Every consumed read counts, the priming read included. When the count reaches `readLimit` (a value of 0 acts as 1) and no decision has been made, the check ends with fail and `timeout` high. A confirming read is still taken when the error read was the last one within the limit.
- R11: `done` is high for exactly one cycle, one cycle after the deciding `rdValid`. `pass` and `timeout` are valid in that cycle and hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a check (ignored while busy) |
| toggleMode | input | 1 | 0 = data polling, 1 = toggle polling |
| expData | input | DATA_W | Byte that was programmed; bit 7 is compared |
| readLimit | input | LIMIT_W | Maximum number of status reads |
| rdReq | output | 1 | Status read request, held until `rdValid` |
| rdValid | input | 1 | Status byte on `rdData` is valid |
| rdData | input | DATA_W | Status byte from the flash |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded |
| timeout | output | 1 | Read budget exhausted without a decision |

## Verification
The assertions assume the read responder obeys the handshake. `rdValid` is only high while `rdReq` is high, and never in two consecutive cycles. They also assume `start` comes from a synchronous source.

The bench responder enforces these assumptions. It answers only an asserted request, drops `rdValid` on the next cycle, and inserts zero to two extra idle cycles before each answer. The random status sequences bias bits 5, 6 and 7 so that loops, confirming reads and budget exhaustion all occur. The read budget is kept small enough that every check ends inside the prepared sequence.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int DONE_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ERR_BIT  = 5;

  typedef enum logic [1:0] {S_IDLE, S_PRIME, S_POLL, S_CONFIRM} pollState_t;

  typedef struct packed {
    logic loadCfg;
    logic countRead;
    logic savePrev;
    logic finish;
    logic resPass;
    logic resTimeout;
  } dpCtrl_t;

  typedef struct packed {
    logic modeToggle;
    logic dataMatch;
    logic toggleSame;
    logic errSeen;
    logic limitHit;
  } dpStat_t;
endpackage

// File: rtl/fdp_datapath.sv
module fdp_datapath
  import fdp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctl,
  input  logic               startMode,
  input  logic [DATA_W-1:0]  startExp,
  input  logic [LIMIT_W-1:0] startLimit,
  input  logic [DATA_W-1:0]  rdData,
  output dpStat_t            stat,
  output logic               done,
  output logic               pass,
  output logic               timeout
);
  localparam int CW = LIMIT_W + 1;

  logic               modeQ;
  logic               expBitQ;
  logic [LIMIT_W-1:0] limQ;
  logic [LIMIT_W-1:0] cntQ;
  logic               prevQ;
  logic               doneQ;
  logic               passQ;
  logic               toQ;
  logic [CW-1:0]      limEff;
  logic [CW-1:0]      cntNext;

  always_comb begin
    limEff  = (limQ == '0) ? CW'(1) : {1'b0, limQ};
    cntNext = {1'b0, cntQ} + CW'(1);
  end

  always_comb begin
    stat.modeToggle = modeQ;
    stat.dataMatch  = (rdData[DONE_BIT] == expBitQ);
    stat.toggleSame = (rdData[TOG_BIT] == prevQ);
    stat.errSeen    = rdData[ERR_BIT];
    stat.limitHit   = (cntNext >= limEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      expBitQ <= 1'b0;
      limQ    <= '0;
      cntQ    <= '0;
      prevQ   <= 1'b0;
      doneQ   <= 1'b0;
      passQ   <= 1'b0;
      toQ     <= 1'b0;
    end else begin
      doneQ <= ctl.finish;
      if (ctl.loadCfg) begin
        modeQ   <= startMode;
        expBitQ <= startExp[DONE_BIT];
        limQ    <= startLimit;
        cntQ    <= '0;
        passQ   <= 1'b0;
        toQ     <= 1'b0;
      end
      if (ctl.countRead) cntQ <= cntNext[LIMIT_W-1:0];
      if (ctl.savePrev) prevQ <= rdData[TOG_BIT];
      if (ctl.finish) begin
        passQ <= ctl.resPass;
        toQ   <= ctl.resTimeout;
      end
    end
  end

  assign done    = doneQ;
  assign pass    = passQ;
  assign timeout = toQ;
endmodule

// File: rtl/fdp_ctrl.sv
module fdp_ctrl
  import fdp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    startMode,
  input  logic    rdValid,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    rdReq
);
  pollState_t state;
  pollState_t stateNxt;
  logic       hit;

  assign hit   = stat.modeToggle ? stat.toggleSame : stat.dataMatch;
  assign rdReq = (state != S_IDLE);

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.loadCfg = 1'b1;
          stateNxt    = startMode ? S_PRIME : S_POLL;
        end
      end
      S_PRIME: begin
        if (rdValid) begin
          ctl.countRead = 1'b1;
          ctl.savePrev  = 1'b1;
          if (stat.limitHit) begin
            ctl.finish     = 1'b1;
            ctl.resTimeout = 1'b1;
            stateNxt       = S_IDLE;
          end else begin
            stateNxt = S_POLL;
          end
        end
      end
      S_POLL: begin
        if (rdValid) begin
          ctl.countRead = 1'b1;
          if (hit) begin
            ctl.finish  = 1'b1;
            ctl.resPass = 1'b1;
            stateNxt    = S_IDLE;
          end else if (stat.errSeen) begin
            ctl.savePrev = 1'b1;
            stateNxt     = S_CONFIRM;
          end else if (stat.limitHit) begin
            ctl.finish     = 1'b1;
            ctl.resTimeout = 1'b1;
            stateNxt       = S_IDLE;
          end else begin
            ctl.savePrev = 1'b1;
          end
        end
      end
      S_CONFIRM: begin
        if (rdValid) begin
          ctl.countRead = 1'b1;
          ctl.finish    = 1'b1;
          ctl.resPass   = hit;
          stateNxt      = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fdp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               toggleMode,
  input  logic [DATA_W-1:0]  expData,
  input  logic [LIMIT_W-1:0] readLimit,
  output logic               rdReq,
  input  logic               rdValid,
  input  logic [DATA_W-1:0]  rdData,
  output logic               done,
  output logic               pass,
  output logic               timeout
);
  dpCtrl_t ctl;
  dpStat_t stat;

  fdp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .startMode(toggleMode),
    .rdValid(rdValid), .stat(stat), .ctl(ctl), .rdReq(rdReq)
  );

  fdp_datapath #(.DATA_W(DATA_W), .LIMIT_W(LIMIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startMode(toggleMode),
    .startExp(expData), .startLimit(readLimit), .rdData(rdData),
    .stat(stat), .done(done), .pass(pass), .timeout(timeout)
  );
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic rdReq,
  input logic rdValid,
  input logic done,
  input logic pass,
  input logic timeout
);
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(rdValid) && !rdReq));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> rdReq);

  p_req_needs_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdReq) |-> $past(start));

  p_timeout_fails_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && timeout) |-> !pass);

  p_result_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (done || ($stable(pass) && $stable(timeout))));
endmodule

bind flash_done_poller fdp_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .rdReq(rdReq), .rdValid(rdValid),
  .done(done), .pass(pass), .timeout(timeout)
);

// File: tb/tb_flash_done_poller.sv
`timescale 1ns/1ps
module tb_flash_done_poller;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       toggleMode = 1'b0;
  logic [7:0] expData = '0;
  logic [7:0] readLimit = '0;
  logic       rdReq;
  logic       rdValid = 1'b0;
  logic [7:0] rdData = '0;
  logic       done, pass, timeout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] seq [64];
  int rdIdx = 0;
  int dly = 0;
  bit expPass, expTo;
  int expReads;

  always #2.5 clk = ~clk;

  flash_done_poller dut (
    .clk(clk), .rstN(rstN), .start(start), .toggleMode(toggleMode),
    .expData(expData), .readLimit(readLimit), .rdReq(rdReq),
    .rdValid(rdValid), .rdData(rdData), .done(done), .pass(pass),
    .timeout(timeout)
  );

  always @(negedge clk) begin
    cycles++;
    if (rdValid) rdValid = 1'b0;
    else if (rdReq) begin
      if (dly > 0) dly--;
      else if (rdIdx < 64) begin
        rdValid = 1'b1;
        rdData  = seq[rdIdx];
        rdIdx++;
        dly = $urandom_range(0, 2);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void refRun(input bit mode, input logic [7:0] e, input int lim);
    int i = 0;
    int l = (lim == 0) ? 1 : lim;
    logic prev = 1'b0;
    expPass = 0; expTo = 0;
    if (mode) begin
      prev = seq[0][6]; i = 1;
      if (i >= l) begin expTo = 1; expReads = i; return; end
    end
    while (i < 62) begin
      logic [7:0] d = seq[i];
      bit hitNow;
      i++;
      hitNow = mode ? (d[6] == prev) : (d[7] == e[7]);
      if (hitNow) begin expPass = 1; expReads = i; return; end
      if (d[5]) begin
        logic [7:0] d2 = seq[i];
        i++;
        expPass = mode ? (d2[6] == d[6]) : (d2[7] == e[7]);
        expReads = i; return;
      end
      if (i >= l) begin expTo = 1; expReads = i; return; end
      prev = d[6];
    end
    expReads = i;
  endfunction

  task automatic runCase(input bit mode, input logic [7:0] e, input int lim,
                         input bit inject, input string tag);
    int cyc = 0;
    bit injected = 0;
    bit p;
    refRun(mode, e, lim);
    rdIdx = 0;
    dly = $urandom_range(0, 2);
    @(negedge clk);
    start = 1'b1; toggleMode = mode; expData = e; readLimit = 8'(lim);
    @(negedge clk);
    chk(rdReq == 1'b1, "R2", {tag, " rdReq after start"}, int'(rdReq), 1);
    start = 1'b0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (start) start = 1'b0;
      if (inject && !injected && !done && rdReq && cyc == 1) begin
        start = 1'b1; toggleMode = ~mode; expData = ~e; readLimit = 8'd1;
        injected = 1;
      end
    end
    start = 1'b0;
    chk(done == 1'b1, "R11", {tag, " done seen"}, int'(done), 1);
    chk(pass == expPass, mode ? "R8" : "R4", {tag, " pass"}, int'(pass), int'(expPass));
    chk(timeout == expTo, "R10", {tag, " timeout"}, int'(timeout), int'(expTo));
    chk(rdIdx == expReads, inject ? "R2" : "R3", {tag, " read count"}, rdIdx, expReads);
    chk(rdReq == 1'b0, "R3", {tag, " rdReq low at done"}, int'(rdReq), 0);
    p = pass;
    @(negedge clk);
    chk(done == 1'b0, "R11", {tag, " done one cycle"}, int'(done), 0);
    chk(pass == p, "R11", {tag, " pass held"}, int'(pass), int'(p));
  endtask

  task automatic genSeq(input bit mode, input logic [7:0] e);
    logic b6 = 1'($urandom_range(0, 1));
    for (int i = 0; i < 64; i++) begin
      logic [7:0] b = 8'($urandom);
      if (mode) begin
        if (i > 0 && $urandom_range(0, 99) < 85) b6 = ~b6;
        b[6] = b6;
      end else begin
        b[7] = ($urandom_range(0, 99) < 15) ? e[7] : ~e[7];
      end
      b[5] = ($urandom_range(0, 99) < 10);
      seq[i] = b;
    end
  endtask

  task automatic setSeq(input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [7:0] d);
    for (int i = 0; i < 64; i++) seq[i] = 8'h00;
    seq[0] = a; seq[1] = b; seq[2] = c; seq[3] = d;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) seq[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(rdReq == 0 && done == 0 && pass == 0 && timeout == 0, "R1", "reset outputs",
        int'({rdReq, done, pass, timeout}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdReq == 0 && done == 0, "R1", "idle after reset", int'({rdReq, done}), 0);

    setSeq(8'h80, 8'h00, 8'h00, 8'h00); runCase(0, 8'h80, 10, 0, "R4 first read match");
    setSeq(8'h00, 8'h00, 8'h80, 8'h00); runCase(0, 8'h80, 10, 0, "R5 loop then match");
    setSeq(8'h20, 8'h80, 8'h00, 8'h00); runCase(0, 8'h80, 10, 0, "R6 confirm pass");
    setSeq(8'h20, 8'h20, 8'h80, 8'h00); runCase(0, 8'h80, 10, 0, "R6 confirm fail");
    setSeq(8'h40, 8'h40, 8'h00, 8'h00); runCase(1, 8'h00, 10, 0, "R7 prime then same");
    setSeq(8'h00, 8'h40, 8'h00, 8'h00); runCase(1, 8'h00, 10, 0, "R8 toggle loop");
    setSeq(8'h00, 8'h60, 8'h00, 8'h40); runCase(1, 8'h00, 10, 0, "R9 confirm fail");
    setSeq(8'h00, 8'h60, 8'h40, 8'h00); runCase(1, 8'h00, 10, 0, "R9 confirm pass");
    setSeq(8'h00, 8'h00, 8'h00, 8'h80); runCase(0, 8'h80, 3, 0, "R10 limit three");
    setSeq(8'h00, 8'h80, 8'h00, 8'h00); runCase(0, 8'h80, 0, 0, "R10 limit zero");
    setSeq(8'h00, 8'h00, 8'h00, 8'h00); runCase(1, 8'h00, 1, 0, "R10 toggle prime limit");
    setSeq(8'h00, 8'h20, 8'h80, 8'h00); runCase(0, 8'h80, 2, 0, "R10 confirm past limit");
    setSeq(8'h00, 8'h00, 8'h00, 8'h80); runCase(0, 8'h80, 10, 1, "R2 start while busy");

    for (int n = 0; n < 60; n++) begin
      bit m = 1'($urandom_range(0, 1));
      logic [7:0] e = 8'($urandom);
      genSeq(m, e);
      runCase(m, e, $urandom_range(1, 40), 1'($urandom_range(0, 3) == 0), "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule